// File: doc/BRIEF.md
# CCD Field Region Sequencer

The block keeps the pixel and line position inside one vertical readout field of an image sensor timing generator. A pixel counter runs every clock. A line counter advances at the end of each line. From the line count and six ascending boundary lines, the block works out which of seven regions is current. It then reports that region's vertical-sequence index and its sweep and multiplier mode flags. The waveform generators downstream use these outputs to shape the vertical clocks.

Six field register sets are held inside the block and are written through a simple wide write port. Each set defines the field length in lines, a shortened pixel count for the final line, the region boundaries and per-region settings, and the sensor-gate controls. The sensor-gate controls are two gate lines (the second is optional), a second vertical pattern group for the gate line, a per-output mask and a per-output pattern number. A selection input picks the set for the next field. The choice is taken only at the field boundary, so a field always runs under a single set.

Top module: `ccd_field_region_seq`

## Requirements
- R1: `pix_cnt` starts at 0 and rises by one each clock. A line ends on the clock where `pix_cnt + 1` is at least the line length. On the next clock `pix_cnt` returns to 0 and `line_cnt` rises by one. Every line except the last uses `line_pixels` as its length. A length of 0 behaves as 1.
- R2: The field has N lines, where N is set-word bits [125:114] and 0 behaves as 1. The final line's length is bits [137:126] instead of `line_pixels`, with 0 behaving as 1. `field_done` is high exactly on the final pixel of the final line, and on the next clock both counters are 0.
- R3: `region` is the highest k in 1..6 whose change position (12 bits at set-word offset 42+12*(k-1)) is less than or equal to `line_cnt`. If there is no such k, `region` is 0.
- R4: `vseq` equals the 4-bit sequence selector of the current region r, held at set-word bits [4r+3:4r].
- R5: `sweep` equals set-word bit 28+r and `multi` equals bit 35+r, where r is the current region.
- R6: `sg_line` is high when `line_cnt` equals the first gate line (bits [149:138]). It is also high when bit 162 is set and `line_cnt` equals the second gate line (bits [161:150]). `vpat2_on` follows `sg_line`, and `vpat2` shows bits [166:163].
- R7: Bit i of `sg_en` (i = 0..4, output i+1) is high only when `sg_line` is high and mask bit 167+i is 0. A mask bit of 1 forces that output low.
- R8: `sg_pat` shows the pattern numbers in set-word bits [181:172]. Output i+1 uses `sg_pat[2i+1:2i]`.
- R9: `field_set` changes only on the clock that follows a cycle with `field_done` high. It then takes `field_sel`, but only if `field_sel` is below 6. Otherwise it keeps its value.
- R10: When `wr_en` is high and `wr_idx` is below 6, `wr_data` replaces stored set `wr_idx` at the clock edge. A write with `wr_idx` of 6 or 7 changes no stored set. The outputs follow the stored contents of the active set at all times.
- R11: After reset, both counters are 0, `field_set` is 0 and every stored set is all zeros.

Set-word fields not listed above: none. The word is 182 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_pixels | input | 12 | Normal line length in pixels |
| field_sel | input | 3 | Set to use for the next field |
| wr_en | input | 1 | Write strobe for the set store |
| wr_idx | input | 3 | Set written |
| wr_data | input | 182 | New set word |
| line_cnt | output | 12 | Current line in the field |
| pix_cnt | output | 12 | Current pixel in the line |
| field_set | output | 3 | Set governing the current field |
| region | output | 3 | Current region 0..6 |
| vseq | output | 4 | Active vertical-sequence index |
| sweep | output | 1 | Sweep mode for the region |
| multi | output | 1 | Multiplier mode for the region |
| sg_line | output | 1 | Current line is a sensor-gate line |
| vpat2_on | output | 1 | Second pattern group applies |
| vpat2 | output | 4 | Second pattern group number |
| sg_en | output | 5 | Sensor-gate output enables |
| sg_pat | output | 10 | Pattern number per gate output |
| field_done | output | 1 | Final pixel of the field |

## Verification
The first set has twenty lines, a three-pixel final line and six distinct boundaries. It shows whether every region switches on exactly its boundary line and whether the short line ends the field. The second set has duplicate boundaries, boundaries past the field end, a gate line on the final line and every output masked. It shows the highest-index rule and masking. Out-of-range selections and writes, a live rewrite of the active set and a zero line length separate an ignored input from one that leaks in, and show that one-pixel lines are handled.

// File: rtl/ccd_field_region_seq.sv
module ccd_field_region_seq #(
  parameter int NSETS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [11:0]  line_pixels,
  input  logic [2:0]   field_sel,
  input  logic         wr_en,
  input  logic [2:0]   wr_idx,
  input  logic [181:0] wr_data,
  output logic [11:0]  line_cnt,
  output logic [11:0]  pix_cnt,
  output logic [2:0]   field_set,
  output logic [2:0]   region,
  output logic [3:0]   vseq,
  output logic         sweep,
  output logic         multi,
  output logic         sg_line,
  output logic         vpat2_on,
  output logic [3:0]   vpat2,
  output logic [4:0]   sg_en,
  output logic [9:0]   sg_pat,
  output logic         field_done
);
  localparam int SW   = 182;
  localparam int OSEQ = 0;
  localparam int OSWP = 28;
  localparam int OMUL = 35;
  localparam int OSCP = 42;
  localparam int OTOT = 114;
  localparam int OLST = 126;
  localparam int OSG1 = 138;
  localparam int OSG2 = 150;
  localparam int OS2E = 162;
  localparam int OVP2 = 163;
  localparam int OMSK = 167;
  localparam int OPAT = 172;

  logic [SW-1:0] bank [NSETS];
  logic [SW-1:0] cur;
  logic          last_line, line_end;
  logic [11:0]   cur_len;

  assign cur       = bank[field_set];
  assign last_line = ({1'b0, line_cnt} + 13'd1) >= {1'b0, cur[OTOT +: 12]};
  assign cur_len   = last_line ? cur[OLST +: 12] : line_pixels;
  assign line_end  = ({1'b0, pix_cnt} + 13'd1) >= {1'b0, cur_len};
  assign field_done = line_end && last_line;

  always_comb begin
    region = 3'd0;
    for (int k = 1; k <= 6; k++)
      if (line_cnt >= cur[OSCP + 12*(k-1) +: 12]) region = 3'(k);
  end

  assign vseq     = cur[OSEQ + 4*region +: 4];
  assign sweep    = cur[OSWP + region];
  assign multi    = cur[OMUL + region];
  assign sg_line  = (line_cnt == cur[OSG1 +: 12]) ||
                    (cur[OS2E] && (line_cnt == cur[OSG2 +: 12]));
  assign vpat2_on = sg_line;
  assign vpat2    = cur[OVP2 +: 4];
  assign sg_en    = sg_line ? ~cur[OMSK +: 5] : 5'd0;
  assign sg_pat   = cur[OPAT +: 10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt   <= '0;
      line_cnt  <= '0;
      field_set <= '0;
    end else if (field_done) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      if (32'(field_sel) < NSETS) field_set <= field_sel;
    end else if (line_end) begin
      pix_cnt  <= '0;
      line_cnt <= line_cnt + 12'd1;
    end else begin
      pix_cnt <= pix_cnt + 12'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) bank[s] <= '0;
    end else if (wr_en && 32'(wr_idx) < NSETS) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assert_pix_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> pix_cnt == $past(pix_cnt) + 12'd1);

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !field_done) |=> (pix_cnt == 12'd0 && line_cnt == $past(line_cnt) + 12'd1));

  assert_field_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |=> (line_cnt == 12'd0 && pix_cnt == 12'd0));

  assert_set_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !field_done |=> $stable(field_set));

  assert_sg_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_en != 5'd0) |-> sg_line);
endmodule

// File: tb/tb_ccd_field_region_seq.sv
module tb_ccd_field_region_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  line_pixels = '0;
  logic [2:0]   field_sel = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic [181:0] wr_data = '0;
  logic [11:0]  line_cnt, pix_cnt;
  logic [2:0]   field_set, region;
  logic [3:0]   vseq, vpat2;
  logic         sweep, multi, sg_line, vpat2_on, field_done;
  logic [4:0]   sg_en;
  logic [9:0]   sg_pat;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [181:0] mbank [6];
  int mline = 0, mpix = 0, mset = 0;

  always #10 clk = ~clk;

  ccd_field_region_seq dut (
    .clk(clk), .rst_n(rst_n), .line_pixels(line_pixels), .field_sel(field_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .line_cnt(line_cnt), .pix_cnt(pix_cnt), .field_set(field_set), .region(region),
    .vseq(vseq), .sweep(sweep), .multi(multi), .sg_line(sg_line), .vpat2_on(vpat2_on),
    .vpat2(vpat2), .sg_en(sg_en), .sg_pat(sg_pat), .field_done(field_done));

  function automatic int fld(int s, int off, int w);
    logic [181:0] t;
    t = mbank[s] >> off;
    return int'(t[31:0]) & ((1 << w) - 1);
  endfunction

  function automatic logic [181:0] put(logic [181:0] w, int off, int wd, int v);
    for (int b = 0; b < wd; b++) w[off + b] = v[b];
    return w;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s line %0d pix %0d: got %0d expected %0d", tag, mline, mpix, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int m_region();
    int r = 0;
    for (int k = 1; k <= 6; k++) if (mline >= fld(mset, 42 + 12*(k-1), 12)) r = k;
    return r;
  endfunction

  function automatic bit m_sgline();
    return (mline == fld(mset, 138, 12)) ||
           (fld(mset, 162, 1) == 1 && mline == fld(mset, 150, 12));
  endfunction

  function automatic bit m_done();
    bit last = (mline + 1) >= eff(fld(mset, 114, 12));
    int len  = last ? eff(fld(mset, 126, 12)) : eff(int'(line_pixels));
    return last && (mpix + 1 >= len);
  endfunction

  task automatic compare();
    int r = m_region();
    bit g = m_sgline();
    chk("R1 pix_cnt", int'(pix_cnt), mpix);
    chk("R1 line_cnt", int'(line_cnt), mline);
    chk("R2 field_done", int'(field_done), int'(m_done()));
    chk("R9 field_set", int'(field_set), mset);
    chk("R3 region", int'(region), r);
    chk("R4 vseq", int'(vseq), fld(mset, 4*r, 4));
    chk("R5 sweep", int'(sweep), fld(mset, 28 + r, 1));
    chk("R5 multi", int'(multi), fld(mset, 35 + r, 1));
    chk("R6 sg_line", int'(sg_line), int'(g));
    chk("R6 vpat2_on", int'(vpat2_on), int'(g));
    chk("R6 vpat2", int'(vpat2), fld(mset, 163, 4));
    chk("R7 sg_en", int'(sg_en), g ? (~fld(mset, 167, 5) & 31) : 0);
    chk("R8 sg_pat", int'(sg_pat), fld(mset, 172, 10));
  endtask

  task automatic model_next();
    bit last = (mline + 1) >= eff(fld(mset, 114, 12));
    int len  = last ? eff(fld(mset, 126, 12)) : eff(int'(line_pixels));
    if (mpix + 1 >= len) begin
      mpix = 0;
      if (last) begin
        mline = 0;
        if (field_sel < 6) mset = int'(field_sel);
      end else mline++;
    end else mpix++;
    if (wr_en && wr_idx < 6) mbank[wr_idx] = wr_data;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      model_next();
      @(negedge clk);
      compare();
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(int idx, logic [181:0] d);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
    cyc(1);
  endtask

  function automatic logic [181:0] mkset(int seq0, int seq1, int seq2, int seq3,
      int seq4, int seq5, int seq6, int swp, int mul, int p1, int p2, int p3,
      int p4, int p5, int p6, int tot, int lst, int g1, int g2, int g2e,
      int vp, int msk, int pat);
    logic [181:0] w = '0;
    w = put(w, 0, 4, seq0);  w = put(w, 4, 4, seq1);  w = put(w, 8, 4, seq2);
    w = put(w, 12, 4, seq3); w = put(w, 16, 4, seq4); w = put(w, 20, 4, seq5);
    w = put(w, 24, 4, seq6);
    w = put(w, 28, 7, swp);  w = put(w, 35, 7, mul);
    w = put(w, 42, 12, p1);  w = put(w, 54, 12, p2); w = put(w, 66, 12, p3);
    w = put(w, 78, 12, p4);  w = put(w, 90, 12, p5); w = put(w, 102, 12, p6);
    w = put(w, 114, 12, tot); w = put(w, 126, 12, lst);
    w = put(w, 138, 12, g1);  w = put(w, 150, 12, g2); w = put(w, 162, 1, g2e);
    w = put(w, 163, 4, vp);   w = put(w, 167, 5, msk); w = put(w, 172, 10, pat);
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [181:0] sa, sb;
    for (int s = 0; s < 6; s++) mbank[s] = '0;
    sa = mkset(3, 1, 4, 1, 5, 9, 2, 7'h0c, 7'h51, 2, 5, 7, 10, 12, 15,
               20, 3, 4, 9, 1, 7, 5'b01010, 10'b1110010011);
    sb = mkset(9, 8, 7, 6, 5, 4, 3, 7'h55, 7'h2a, 2, 2, 3, 100, 100, 4000,
               8, 0, 7, 0, 0, 9, 5'h1f, 10'h3a5);
    repeat (3) @(negedge clk);
    // R11 reset state, observed while reset is held
    chk("R11 reset line_cnt", int'(line_cnt), 0);
    chk("R11 reset pix_cnt", int'(pix_cnt), 0);
    chk("R11 reset field_set", int'(field_set), 0);
    chk("R11 reset sg_en", int'(sg_en), 31);
    rst_n = 1'b1;
    compare();
    line_pixels = 12'd5;
    wr(0, sa);
    wr(1, sb);
    // R10 out-of-range writes must not land in any set
    wr(6, {182{1'b1}});
    wr(7, sb);
    cyc(300);
    field_sel = 3'd1;
    cyc(150);
    field_sel = 3'd7;            // R9 invalid selection keeps current set
    cyc(120);
    field_sel = 3'd6;
    cyc(60);
    field_sel = 3'd0;
    cyc(200);
    // R10 live rewrite of the active set: second gate line off, new mask
    wr(0, put(put(sa, 162, 1, 0), 167, 5, 5'b10001));
    cyc(220);
    line_pixels = 12'd0;         // R1 zero length behaves as one
    cyc(80);
    line_pixels = 12'd2;
    field_sel = 3'd1;
    cyc(200);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule